// File: doc/BRIEF.md
# Extended stack pointer unit

This block keeps the stack pointer of a small microcontroller core and supplies the RAM address of every stack access. The pointer is normally 8 bits wide. When the core's configuration enables the extension, it becomes 11 bits wide. The three extra bits live in a separate high byte. Software reaches the pointer through two direct-addressed special-register locations: the low byte at 81H and the high byte at B7H.

The core sequencer raises `push_req` for every byte it stores on the stack. A call that stores a return address is two pushes in consecutive cycles: the low return byte first, then the high byte. The sequencer raises `pop_req` for every byte it takes off the stack.

A push uses pre-increment, so the write address is the incremented pointer. A pop uses post-decrement, so the read address is the current pointer. `stk_addr` is combinational. It carries the access address in the same cycle as the request, and the pointer register moves at the next clock edge.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset, the low byte reads 07H, the high byte reads 00H (with the extension enabled), and `stk_addr` is 007H. The first push therefore writes address 008H.
- R2: On an accepted push, `stk_addr` equals the pointer plus one in that cycle, and the pointer takes that value at the next edge. Two pushes in consecutive cycles (a call) give consecutive addresses.
- R3: On an accepted pop, `stk_addr` equals the current pointer, and the pointer decrements by one at the next edge.
- R4: While `ext_en` is 0, `stk_addr[10:8]` is zero. The pointer wraps within 8 bits: FFH+1 gives 00H and 00H-1 gives FFH. The stored high bits are not changed.
- R5: While `ext_en` is 1, a carry out of the low byte goes into the high bits, a borrow comes out of them, and the 11-bit pointer wraps modulo 2048 (7FFH+1 gives 000H).
- R6: A register write to address 81H loads the low byte from `sfr_wdata`. A read at 81H returns the low byte.
- R7: While `ext_en` is 1, a write to B7H loads the high bits from `sfr_wdata[2:0]`. A read at B7H returns the high bits in bits 2:0, and bits 7:3 always read zero.
- R8: While `ext_en` is 0, a write to B7H has no effect and a read at B7H returns 00H. Stored high bits reappear when the extension is enabled again.
- R9: A register write that takes effect on either pointer byte in the same cycle as a push or pop wins. The push or pop is dropped, and `stk_addr` shows the unchanged pointer.
- R10: If push and pop are requested together, the push is performed and the pop is ignored.
- R11: Writes to any other address leave the pointer unchanged. Reads at any other address return 00H.
- R12: With no write, push or pop, the pointer holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_en | input | 1 | Extension enable from the configuration register |
| sfr_wr_en | input | 1 | Special-register write strobe |
| sfr_addr | input | 8 | Direct special-register address |
| sfr_wdata | input | 8 | Special-register write data |
| sfr_rdata | output | 8 | Read data for the addressed pointer byte, 00H otherwise |
| push_req | input | 1 | Store one byte on the stack (pre-increment) |
| pop_req | input | 1 | Take one byte from the stack (post-decrement) |
| stk_addr | output | 11 | RAM address of this cycle's stack access |

## Verification
The assertions check these properties on every cycle:
- the high address bits are zero while the extension is off;
- B7H reads zero while hidden, and its upper five bits always read zero;
- a blocked B7H write leaves the high bits unchanged;
- a low-byte write always wins;
- an idle cycle holds the pointer;
- an accepted push lands the pointer on the address that was presented.

Only the bench scenarios can show:
- the reset value;
- the exact 8-bit and 11-bit wrap and carry/borrow points;
- the reappearance of stored high bits after re-enabling;
- push-over-pop priority;
- consecutive call addresses.

For these, the bench compares every cycle's address and read data against a reference model driven by mixed random and directed operations.

// File: rtl/stkp_pkg.sv
package stkp_pkg;
    parameter int SP_LO_W = 8;
    parameter int SP_HI_W = 3;
    parameter int SFR_W   = 8;
    parameter int PTR_W   = SP_LO_W + SP_HI_W;

    typedef struct packed {
        logic [SP_HI_W-1:0] hi;
        logic [SP_LO_W-1:0] lo;
    } sp_t;

    typedef enum logic [1:0] {
        SP_HOLD = 2'd0,
        SP_INC  = 2'd1,
        SP_DEC  = 2'd2
    } sp_op_e;

    typedef struct packed {
        sp_t sp;
    } stkp_state_t;
endpackage

// File: rtl/stkp_step.sv
module stkp_step
    import stkp_pkg::*;
(
    input  sp_t              cur,
    input  logic             ext_en,
    input  sp_op_e           op,
    output sp_t              nxt,
    output logic [PTR_W-1:0] cur_addr,
    output logic [PTR_W-1:0] nxt_addr
);
    logic [PTR_W-1:0] wide;
    logic [PTR_W-1:0] stepped;

    always_comb begin
        wide = {(ext_en ? cur.hi : {SP_HI_W{1'b0}}), cur.lo};
        unique case (op)
            SP_INC:  stepped = wide + 1'b1;
            SP_DEC:  stepped = wide - 1'b1;
            default: stepped = wide;
        endcase
        nxt.lo   = stepped[SP_LO_W-1:0];
        nxt.hi   = ext_en ? stepped[PTR_W-1:SP_LO_W] : cur.hi;
        cur_addr = wide;
        nxt_addr = {(ext_en ? stepped[PTR_W-1:SP_LO_W] : {SP_HI_W{1'b0}}),
                    stepped[SP_LO_W-1:0]};
    end
endmodule

// File: rtl/stkp_sfr_if.sv
module stkp_sfr_if
    import stkp_pkg::*;
#(
    parameter logic [SFR_W-1:0] LO_ADDR = 8'h81,
    parameter logic [SFR_W-1:0] HI_ADDR = 8'hB7
) (
    input  logic             wr_en,
    input  logic [SFR_W-1:0] addr,
    input  logic             ext_en,
    input  sp_t              cur,
    output logic             wr_lo,
    output logic             wr_hi,
    output logic [SFR_W-1:0] rdata
);
    localparam int PAD_W = SFR_W - SP_HI_W;

    logic sel_lo;
    logic sel_hi;

    always_comb begin
        sel_lo = (addr == LO_ADDR);
        sel_hi = (addr == HI_ADDR) && ext_en;
        wr_lo  = wr_en && sel_lo;
        wr_hi  = wr_en && sel_hi;
        if (sel_lo)
            rdata = cur.lo;
        else if (sel_hi)
            rdata = {{PAD_W{1'b0}}, cur.hi};
        else
            rdata = '0;
    end
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
    import stkp_pkg::*;
#(
    parameter logic [SFR_W-1:0]   LO_ADDR = 8'h81,
    parameter logic [SFR_W-1:0]   HI_ADDR = 8'hB7,
    parameter logic [SP_LO_W-1:0] RST_LO  = 8'h07
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_en,
    input  logic             sfr_wr_en,
    input  logic [SFR_W-1:0] sfr_addr,
    input  logic [SFR_W-1:0] sfr_wdata,
    output logic [SFR_W-1:0] sfr_rdata,
    input  logic             push_req,
    input  logic             pop_req,
    output logic [PTR_W-1:0] stk_addr
);
    stkp_state_t      state_d, state_q;
    sp_op_e           op_d;
    sp_t              step_nxt;
    logic [PTR_W-1:0] cur_addr, nxt_addr;
    logic             wr_lo, wr_hi, wr_any;

    stkp_sfr_if #(
        .LO_ADDR (LO_ADDR),
        .HI_ADDR (HI_ADDR)
    ) u_sfr (
        .wr_en  (sfr_wr_en),
        .addr   (sfr_addr),
        .ext_en (ext_en),
        .cur    (state_q.sp),
        .wr_lo  (wr_lo),
        .wr_hi  (wr_hi),
        .rdata  (sfr_rdata)
    );

    stkp_step u_step (
        .cur      (state_q.sp),
        .ext_en   (ext_en),
        .op       (op_d),
        .nxt      (step_nxt),
        .cur_addr (cur_addr),
        .nxt_addr (nxt_addr)
    );

    always_comb begin
        wr_any  = wr_lo || wr_hi;
        op_d    = SP_HOLD;
        if (!wr_any) begin
            if (push_req)
                op_d = SP_INC;
            else if (pop_req)
                op_d = SP_DEC;
        end
        state_d = state_q;
        if (wr_lo)
            state_d.sp.lo = sfr_wdata[SP_LO_W-1:0];
        else if (wr_hi)
            state_d.sp.hi = sfr_wdata[SP_HI_W-1:0];
        else if (op_d != SP_HOLD)
            state_d.sp = step_nxt;
        stk_addr = (op_d == SP_INC) ? nxt_addr : cur_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.sp.lo <= RST_LO;
            state_q.sp.hi <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // R2
    push_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !wr_any && ext_en) |=> (state_q.sp == $past(stk_addr)));

    // R2
    push_lands_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !wr_any && !ext_en) |=> (state_q.sp.lo == $past(stk_addr[SP_LO_W-1:0])));

    // R4
    narrow_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_en |-> (stk_addr[PTR_W-1:SP_LO_W] == '0));

    // R8
    hidden_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_en && sfr_addr == HI_ADDR) |-> (sfr_rdata == '0));

    // R8
    hidden_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_en && sfr_wr_en && sfr_addr == HI_ADDR) |=> $stable(state_q.sp.hi));

    // R7
    hi_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr == HI_ADDR) |-> (sfr_rdata[SFR_W-1:SP_HI_W] == '0));

    // R9
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_wr_en && sfr_addr == LO_ADDR) |=> (state_q.sp.lo == $past(sfr_wdata[SP_LO_W-1:0])));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_req && !pop_req && !sfr_wr_en) |=> $stable(state_q.sp));
endmodule

// File: tb/tb_stack_ptr_unit.sv
module tb_stack_ptr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_en = 1'b0;
    logic        sfr_wr_en = 1'b0;
    logic [7:0]  sfr_addr = 8'h00;
    logic [7:0]  sfr_wdata = 8'h00;
    logic [7:0]  sfr_rdata;
    logic        push_req = 1'b0;
    logic        pop_req = 1'b0;
    logic [10:0] stk_addr;

    int total = 0;
    int bad = 0;
    logic [7:0] m_lo = 8'h07;
    logic [2:0] m_hi = 3'h0;

    always #10 clk = ~clk;

    stack_ptr_unit dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_en    (ext_en),
        .sfr_wr_en (sfr_wr_en),
        .sfr_addr  (sfr_addr),
        .sfr_wdata (sfr_wdata),
        .sfr_rdata (sfr_rdata),
        .push_req  (push_req),
        .pop_req   (pop_req),
        .stk_addr  (stk_addr)
    );

    function automatic logic [10:0] m_ptr(input logic e);
        return {(e ? m_hi : 3'h0), m_lo};
    endfunction

    function automatic logic m_wrany(input logic w, input logic [7:0] a, input logic e);
        return w && (a == 8'h81 || (a == 8'hB7 && e));
    endfunction

    function automatic logic [10:0] m_addr(input logic p, input logic w,
                                           input logic [7:0] a, input logic e);
        logic [10:0] n;
        if (p && !m_wrany(w, a, e)) begin
            n = m_ptr(e) + 11'd1;
            if (!e) n[10:8] = 3'h0;
            return n;
        end
        return m_ptr(e);
    endfunction

    function automatic logic [7:0] m_rd(input logic [7:0] a, input logic e);
        if (a == 8'h81) return m_lo;
        if (a == 8'hB7 && e) return {5'h00, m_hi};
        return 8'h00;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic p, input logic po, input logic w,
                        input logic [7:0] a, input logic [7:0] d,
                        input logic e, input string req);
        logic [10:0] n;
        @(negedge clk);
        push_req = p; pop_req = po; sfr_wr_en = w;
        sfr_addr = a; sfr_wdata = d; ext_en = e;
        #2;
        chk({req, " addr"}, 32'(stk_addr), 32'(m_addr(p, w, a, e)));
        chk({req, " rdata"}, 32'(sfr_rdata), 32'(m_rd(a, e)));
        @(posedge clk);
        if (w && a == 8'h81) m_lo = d;
        else if (w && a == 8'hB7 && e) m_hi = d[2:0];
        else if (p || po) begin
            n = p ? m_ptr(e) + 11'd1 : m_ptr(e) - 11'd1;
            m_lo = n[7:0];
            if (e) m_hi = n[10:8];
        end
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_up();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset values
        step(0, 0, 0, 8'h81, 8'h00, 1, "R1");
        step(0, 0, 0, 8'hB7, 8'h00, 1, "R1");
        // R2 call: two consecutive pushes, first at 008H
        step(1, 0, 0, 8'h00, 8'h00, 0, "R2");
        step(1, 0, 0, 8'h00, 8'h00, 0, "R2");
        // R3 pop
        step(0, 1, 0, 8'h81, 8'h00, 0, "R3");
        // R6 and R4: 8-bit wrap both ways
        step(0, 0, 1, 8'h81, 8'hFF, 0, "R6");
        step(1, 0, 0, 8'h81, 8'h00, 0, "R4");
        step(0, 1, 0, 8'h81, 8'h00, 0, "R4");
        // R7 high byte write/read, R5 carry, borrow, wrap at 2048
        step(0, 0, 1, 8'hB7, 8'hFA, 1, "R7");
        step(0, 0, 0, 8'hB7, 8'h00, 1, "R7");
        step(1, 0, 0, 8'hB7, 8'h00, 1, "R5");
        step(0, 1, 0, 8'hB7, 8'h00, 1, "R5");
        step(0, 0, 1, 8'hB7, 8'h02, 1, "R5");
        step(0, 0, 1, 8'h81, 8'hFF, 1, "R5");
        step(1, 0, 0, 8'hB7, 8'h00, 1, "R5");
        step(0, 1, 0, 8'hB7, 8'h00, 1, "R5");
        step(0, 0, 1, 8'hB7, 8'h00, 1, "R5");
        step(0, 0, 1, 8'h81, 8'h00, 1, "R5");
        step(0, 1, 0, 8'hB7, 8'h00, 1, "R5");
        // R8 hidden high byte, then reappears
        step(0, 0, 1, 8'hB7, 8'h05, 0, "R8");
        step(0, 0, 0, 8'hB7, 8'h00, 0, "R8");
        step(0, 0, 0, 8'hB7, 8'h00, 1, "R8");
        // R9 write beats push and pop
        step(1, 0, 1, 8'h81, 8'h40, 1, "R9");
        step(0, 1, 1, 8'hB7, 8'h01, 1, "R9");
        step(0, 0, 0, 8'h81, 8'h00, 1, "R9");
        // R10 push and pop together
        step(1, 1, 0, 8'h81, 8'h00, 1, "R10");
        step(0, 0, 0, 8'h81, 8'h00, 1, "R10");
        // R11 foreign address
        step(0, 0, 1, 8'hE0, 8'h99, 1, "R11");
        step(0, 0, 0, 8'h81, 8'h00, 1, "R11");
        step(0, 0, 0, 8'hE0, 8'h00, 1, "R11");
        // R12 idle hold
        step(0, 0, 0, 8'h81, 8'h00, 1, "R12");
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] a;
            int k;
            k = $urandom_range(0, 3);
            a = (k == 0) ? 8'h81 : (k == 1) ? 8'hB7 : 8'($urandom_range(0, 255));
            step(1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 2) == 0),
                 1'($urandom_range(0, 7) == 0), a, 8'($urandom_range(0, 255)),
                 1'($urandom_range(0, 3) != 0), "R2 R3 R5 random");
        end
        finish_up();
    end
endmodule